// File: doc/BRIEF.md
# Single-Line ROM Read Cache

This block sits between a CPU that reads ROM data one byte at a time and a slow external memory that works best when it is asked for short bursts. It holds one line of bytes. A read whose address lies inside the cached range is answered from the line on the next cycle. A read outside the range starts a burst: the fetch begins at the read address rounded down to an alignment, and its length is chosen by a memory-kind input. The burst is cut short at the end of the memory page, so a fetch never spans two pages. The line is tracked by a lowest-address and a highest-address register, not by tags.

The memory is read-only, so the block has no write path and no dirty state. Addresses reach the block already remapped. A flush input empties the line. This is used after the ROM contents or the address mapping have changed.

Top module: `rom_line_cache`

## Requirements
- R1: After reset no range is cached, `rd_valid` and `mem_req` are low, and the first read always issues a fetch.
- R2: The line length and alignment come from `mem_kind`: 0 gives 8 bytes aligned to 4, 1 gives 6 bytes aligned to 2, 2 gives 4 bytes aligned to 1, and 3 gives 6 bytes aligned to 2. `mem_addr` is the read address with its alignment bits cleared.
- R3: A page is 2^PAGE_W bytes. `mem_len` is the smaller of the line length and the number of bytes from `mem_addr` to the end of its page.
- R4: A read at an address from the low bound to the high bound, inclusive, issues no fetch. `rd_valid` rises one cycle after `rd_req`, with the byte at that address.
- R5: On a miss, `mem_req` is high for exactly one cycle, one cycle after `rd_req`. Beat k carries the byte at `mem_addr`+k. `rd_valid` rises one cycle after the last beat, with the requested byte.
- R6: When the last beat arrives, the cached range becomes `mem_addr` to `mem_addr`+`mem_len`-1. Later reads inside this range hit, and a read one byte past it misses.
- R7: A pulse on `flush` empties the line, so the next read misses. A flush in the same cycle as `rd_req` also turns that read into a miss. A flush during a fetch leaves the fetched line uncached after that request has been answered.
- R8: Beats that arrive while no fetch is outstanding are ignored. The cached bytes and the outputs do not change.
- R9: Three consecutive bytes that start anywhere inside one alignment unit are all served by a single fetch.
- R10: Each request produces exactly one `rd_valid` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_kind | input | 2 | Memory kind; selects line length and alignment |
| flush | input | 1 | Empties the cached line |
| rd_req | input | 1 | One-cycle byte read request |
| rd_addr | input | AW | Remapped byte address of the read |
| rd_valid | output | 1 | One-cycle strobe: `rd_data` is valid |
| rd_data | output | 8 | Byte that was read |
| mem_req | output | 1 | One-cycle burst request |
| mem_addr | output | AW | First byte address of the burst |
| mem_len | output | LEN_W | Number of bytes in the burst |
| beat_valid | input | 1 | One returned byte is present |
| beat_data | input | 8 | Returned byte |

## Verification
The assertions assume certain things about the inputs:
- The CPU issues a new `rd_req` only after the `rd_valid` of the previous request.
- `mem_kind` does not change while a fetch is outstanding.
- The memory returns exactly `mem_len` beats, starting no earlier than the cycle after `mem_req`.

The bench's memory responder waits one idle cycle after each request and then streams its beats back to back. `mem_kind` is changed only between reads. Stray beats are injected only while the block is idle, which is the case R8 covers.

// File: rtl/rom_line_cache.sv
module rom_line_cache #(
  parameter int AW       = 24,
  parameter int PAGE_W   = 16,
  parameter int LINE_MAX = 8,
  localparam int LEN_W   = $clog2(LINE_MAX + 1),
  localparam int OFF_W   = $clog2(LINE_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mem_kind,
  input  logic             flush,
  input  logic             rd_req,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic [LEN_W-1:0] mem_len,
  input  logic             beat_valid,
  input  logic [7:0]       beat_data
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;

  state_t           state;
  logic [7:0]       line_q [LINE_MAX];
  logic [AW-1:0]    lo, hi, f_start;
  logic [LEN_W-1:0] f_len, cnt;
  logic [OFF_W-1:0] f_off;
  logic             line_ok, flush_seen;

  logic [LEN_W-1:0] line_sz;
  logic [1:0]       amask;

  always_comb begin
    case (mem_kind)
      2'd0:    begin line_sz = LEN_W'(8); amask = 2'b11; end
      2'd2:    begin line_sz = LEN_W'(4); amask = 2'b00; end
      default: begin line_sz = LEN_W'(6); amask = 2'b01; end
    endcase
  end

  logic [AW-1:0]   start;
  logic [PAGE_W:0] room;
  logic [LEN_W-1:0] len;
  logic            hit;
  logic [AW-1:0]   hit_diff;

  assign start    = rd_addr & ~{{(AW-2){1'b0}}, amask};
  assign room     = (PAGE_W+1)'(1) << PAGE_W;
  assign len      = ((room - {1'b0, start[PAGE_W-1:0]}) < (PAGE_W+1)'(line_sz))
                    ? LEN_W'(room - {1'b0, start[PAGE_W-1:0]}) : line_sz;
  assign hit      = line_ok && !flush && (rd_addr >= lo) && (rd_addr <= hi);
  assign hit_diff = rd_addr - lo;

  assign mem_req  = (state == S_REQ);
  assign mem_addr = f_start;
  assign mem_len  = f_len;

  logic last_beat;
  assign last_beat = (state == S_WAIT) && beat_valid && (cnt == f_len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      line_ok    <= 1'b0;
      flush_seen <= 1'b0;
      lo         <= '0;
      hi         <= '0;
      f_start    <= '0;
      f_len      <= '0;
      f_off      <= '0;
      cnt        <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (flush) line_ok <= 1'b0;
          if (rd_req) begin
            if (hit) begin
              rd_valid <= 1'b1;
              rd_data  <= line_q[hit_diff[OFF_W-1:0]];
            end else begin
              line_ok    <= 1'b0;
              flush_seen <= 1'b0;
              f_start    <= start;
              f_len      <= len;
              f_off      <= OFF_W'(rd_addr - start);
              cnt        <= '0;
              state      <= S_REQ;
            end
          end
        end
        S_REQ: begin
          if (flush) flush_seen <= 1'b1;
          state <= S_WAIT;
        end
        default: begin
          if (flush) flush_seen <= 1'b1;
          if (beat_valid) cnt <= cnt + LEN_W'(1);
          if (last_beat) begin
            state    <= S_IDLE;
            rd_valid <= 1'b1;
            rd_data  <= (LEN_W'(f_off) == cnt) ? beat_data : line_q[f_off];
            line_ok  <= !(flush || flush_seen);
            lo       <= f_start;
            hi       <= f_start + AW'(f_len) - AW'(1);
          end
        end
      endcase
    end
  end

  for (genvar i = 0; i < LINE_MAX; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (state == S_WAIT && beat_valid && cnt == LEN_W'(i))
        line_q[i] <= beat_data;
    end
  end

endmodule

// File: rtl/rom_line_cache_chk.sv
module rom_line_cache_chk #(
  parameter int AW       = 24,
  parameter int PAGE_W   = 16,
  parameter int LINE_MAX = 8,
  localparam int LEN_W   = $clog2(LINE_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mem_kind,
  input logic             flush,
  input logic             rd_valid,
  input logic             mem_req,
  input logic [AW-1:0]    mem_addr,
  input logic [LEN_W-1:0] mem_len,
  input logic             line_ok,
  input logic [AW-1:0]    lo,
  input logic [AW-1:0]    hi
);

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0 && int'(mem_len) <= LINE_MAX)); // R2

  AST_ALIGN_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_kind == 2'd0) |-> (mem_addr[1:0] == 2'b00)); // R2

  AST_ALIGN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_kind[0]) |-> (mem_addr[0] == 1'b0)); // R2

  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (int'(mem_addr[PAGE_W-1:0]) + int'(mem_len) <= (1 << PAGE_W))); // R3

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R5

  AST_REQ_NOT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rd_valid); // R5

  AST_RANGE_FITS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    line_ok |-> (hi >= lo && int'(hi - lo) < LINE_MAX)); // R6

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !line_ok); // R7

endmodule

bind rom_line_cache rom_line_cache_chk #(.AW(AW), .PAGE_W(PAGE_W), .LINE_MAX(LINE_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_kind(mem_kind), .flush(flush), .rd_valid(rd_valid),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
  .line_ok(line_ok), .lo(lo), .hi(hi)
);

// File: tb/rom_line_cache_test.sv
module rom_line_cache_test;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mem_kind = 2'd0;
  logic          flush = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid;
  logic [7:0]    rd_data;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_len;
  logic          resp_valid = 1'b0, inj_valid = 1'b0;
  logic [7:0]    resp_data = '0, inj_data = '0;
  logic          beat_valid;
  logic [7:0]    beat_data;

  assign beat_valid = resp_valid | inj_valid;
  assign beat_data  = inj_valid ? inj_data : resp_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rom_line_cache uut (
    .clk(clk), .rst_n(rst_n), .mem_kind(mem_kind), .flush(flush),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
    .beat_valid(beat_valid), .beat_data(beat_data)
  );

  function automatic logic [7:0] rom(input logic [AW-1:0] a);
    return a[7:0] ^ {a[14:8], 1'b0} ^ a[23:16] ^ 8'h3C;
  endfunction

  // memory responder: one idle cycle, then back-to-back beats
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [AW-1:0] a;
        int n;
        a = mem_addr;
        n = int'(mem_len);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
          resp_valid = 1'b1;
          resp_data  = rom(a + AW'(k));
          @(negedge clk);
        end
        resp_valid = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit with_flush, output logic [7:0] d,
                         output int lat, output bit missed, output logic [AW-1:0] ma, output int ml);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; flush = with_flush;
    missed = 0; ma = '0; ml = 0; lat = 1;
    @(negedge clk);
    rd_req = 1'b0; flush = 1'b0;
    while (!rd_valid && lat < 60) begin
      if (mem_req) begin missed = 1; ma = mem_addr; ml = int'(mem_len); end
      @(negedge clk);
      lat++;
    end
    d = rd_data;
    chk(rd_valid, "R10", "valid seen", int'(rd_valid), 1);
    @(negedge clk);
    chk(!rd_valid, "R10", "valid one cycle", int'(rd_valid), 0);
  endtask

  task automatic expect_miss(input logic [AW-1:0] a, input bit with_flush,
                             input logic [AW-1:0] exp_ma, input int exp_ml, input string req);
    logic [7:0] d; int lat; bit m; logic [AW-1:0] ma; int ml;
    do_read(a, with_flush, d, lat, m, ma, ml);
    chk(m, req, "miss fetched", int'(m), 1);
    chk(ma == exp_ma, req, "mem_addr", int'(ma), int'(exp_ma));
    chk(ml == exp_ml, req, "mem_len", ml, exp_ml);
    chk(d == rom(a), "R5", "miss data", int'(d), int'(rom(a)));
    chk(lat == exp_ml + 2, "R5", "miss latency", lat, exp_ml + 2);
  endtask

  task automatic expect_hit(input logic [AW-1:0] a, input string req);
    logic [7:0] d; int lat; bit m; logic [AW-1:0] ma; int ml;
    do_read(a, 1'b0, d, lat, m, ma, ml);
    chk(!m, req, "hit no fetch", int'(m), 0);
    chk(lat == 1, "R4", "hit latency", lat, 1);
    chk(d == rom(a), req, "hit data", int'(d), int'(rom(a)));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!rd_valid, "R1", "rd_valid after reset", int'(rd_valid), 0);
    chk(!mem_req, "R1", "mem_req after reset", int'(mem_req), 0);
    mem_kind = 2'd0;
    expect_miss(24'h000010, 0, 24'h000010, 8, "R1");
  endtask

  task automatic t_wide;
    mem_kind = 2'd0;
    expect_miss(24'h012345, 0, 24'h012344, 8, "R2");
    expect_hit(24'h012344, "R6");
    expect_hit(24'h01234B, "R6");
    expect_miss(24'h01234C, 0, 24'h01234C, 8, "R6");
  endtask

  task automatic t_byte_and_three;
    mem_kind = 2'd1;
    expect_miss(24'h020007, 0, 24'h020006, 6, "R2");
    expect_hit(24'h020008, "R9");
    expect_hit(24'h020009, "R9");
    mem_kind = 2'd2;
    expect_miss(24'h030003, 0, 24'h030003, 4, "R2");
    expect_hit(24'h030006, "R6");
    mem_kind = 2'd3;
    expect_miss(24'h040101, 0, 24'h040100, 6, "R2");
    expect_hit(24'h040105, "R9");
  endtask

  task automatic t_page;
    mem_kind = 2'd0;
    expect_miss(24'h05FFFD, 0, 24'h05FFFC, 4, "R3");
    expect_hit(24'h05FFFF, "R3");
    expect_miss(24'h060000, 0, 24'h060000, 8, "R3");
  endtask

  task automatic t_flush;
    mem_kind = 2'd0;
    expect_miss(24'h070020, 0, 24'h070020, 8, "R7");
    expect_hit(24'h070021, "R7");
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    expect_miss(24'h070021, 0, 24'h070020, 8, "R7");
    expect_miss(24'h070022, 1, 24'h070020, 8, "R7");
    expect_hit(24'h070023, "R7");
  endtask

  task automatic t_stray;
    mem_kind = 2'd0;
    expect_miss(24'h080040, 0, 24'h080040, 8, "R8");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      inj_valid = 1'b1; inj_data = 8'hFF ^ 8'(k);
      chk(!rd_valid, "R8", "no valid on stray beat", int'(rd_valid), 0);
    end
    @(negedge clk); inj_valid = 1'b0;
    chk(!rd_valid && !mem_req, "R8", "outputs quiet", int'({rd_valid, mem_req}), 0);
    expect_hit(24'h080040, "R8");
    expect_hit(24'h080043, "R8");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wide();
    t_byte_and_three();
    t_page();
    t_flush();
    t_stray();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule